// File: doc/BRIEF.md
# Three-Tier Prioritized Interrupt Controller

This block is the interrupt controller of a small microcontroller. It takes thirteen request sources: six external pins, timer overflow pulses, serial port events, a watchdog event and one auxiliary request. It holds a pending flag for each source, an enable bit for each, a priority bit for each non-auxiliary source, and one global enable. From these it picks one request and presents it to the CPU as a vector request with an 8-bit vector address.

The auxiliary request gathers eight level sub-sources through an 8-bit mask. It always ranks above everything else. The other sources fall into a high or a low group according to their priority bits. Inside a group, a fixed polling order breaks ties.

When the CPU takes a vector, the controller pushes the tier of that source onto an in-service record, and it clears the flags of the sources that hardware clears. A return-from-interrupt pulse pops the most recent tier. A pending request may interrupt a running handler only if its tier is strictly higher. A read-select bit swaps which of two register addresses returns the auxiliary mask and which returns the raw auxiliary inputs.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads 0, `vec_req` is low and no tier is in service.
- R2: Source index i (0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 ser0, 5 tmr2, 6 aux, 7 ser1, 8..11 ext2..ext5, 12 wdog) has vector address 03h + 8*i, so aux is 33h and wdog is 63h.
- R3: Among pending and enabled sources of the same group, the lowest index in the R2 order wins.
- R4: The aux request beats the high group, and any high-group source beats any low-group source. Priority register (address 1) bit i set puts source i in the high group. Bit 6 is always 0.
- R5: The aux flag equals the OR of (aux_raw AND mask), with the mask at address 2 or 3 bits 7:0. It requests only when enable bit 6 is set.
- R6: Enable register (address 0) bits 12:0 enable each source. Bit 15 is a global enable: when it is 0, `vec_req` stays low.
- R7: A flag is set by a rising edge on its external pin, or by a one-cycle event pulse. A set in the same cycle as a clear wins. When a vector is accepted, the flags of ext0..ext5 (edge mode), tmr0 and tmr1 are cleared. All other flags stay set until a 1 is written to their bit of the flag register (address 5).
- R8: When mode register (address 4) bit 0 or bit 1 is 1, the flag of ext0 or ext1 follows the live pin level.
- R9: Address 3 bit 8 is the read-select bit. When it is 1, address 2 reads the mask and address 3 bits 7:0 read the raw aux inputs. When it is 0, the two readbacks are swapped.
- R10: A vector is accepted when `vec_ack` is high while `vec_req` is high and `reti` is low. Acceptance marks the winner's tier (low 0, high 1, aux 2) as in service, and `reti` clears the highest tier in service. `vec_req` is high only when the winner's tier is strictly above every tier in service.
- R11: The enable register reads back bits 12:0 and bit 15. The priority register reads back bits 12:0 with bit 6 forced to 0. The flag register reads back the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 6 | External request pins ext0..ext5 |
| per_evt | input | 6 | Event pulses: tmr0, tmr1, ser0, tmr2, ser1, wdog |
| aux_raw | input | 8 | Auxiliary sub-source levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| vec_ack | input | 1 | CPU takes the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_req | output | 1 | Vector request |
| vec_addr | output | 8 | Vector address of the winner |

## Verification
On every cycle, the assertions check that a presented vector address sits on the 8-byte grid, and that the global enable and the aux enable gate requests. They also check that an accepted timer 0 vector clears that flag, and that each accept or return changes the in-service record by exactly one tier. The bench scenarios are needed for the rest. They show the tie-break order inside a group, the ranking of aux over high over low, and that level-mode flags follow the pin. They also cover a handler that cannot be preempted until a return pops the higher tier, the read-select swap, and the software-only clearing of serial flags.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   localparam int NSRC    = 13;
   localparam int IDX_W   = $clog2(NSRC);
   localparam int AUX_SRC = 6;
   localparam int NEXT    = 6;
   localparam int NPER    = 6;
   localparam int NTIER   = 3;
   localparam int LVL_W   = $clog2(NTIER + 1);

   localparam int EXT_SRC [NEXT] = '{0, 2, 8, 9, 10, 11};
   localparam int PER_SRC [NPER] = '{1, 3, 4, 5, 7, 12};

   localparam logic [NSRC-1:0] HW_CLR  = 13'h0F0F;
   localparam logic [NSRC-1:0] AUX_BIT = NSRC'(1) << AUX_SRC;

   typedef enum logic [2:0] {
      RA_ENA    = 3'd0,
      RA_PRIO   = 3'd1,
      RA_AUXMSK = 3'd2,
      RA_AUXSTS = 3'd3,
      RA_MODE   = 3'd4,
      RA_FLAG   = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      TIER_LO  = 2'd0,
      TIER_HI  = 2'd1,
      TIER_AUX = 2'd2
   } tier_e;

   function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (v[i]) r = IDX_W'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/irqc_flags.sv
`timescale 1ns/1ps
module irqc_flags
   import irqc_pkg::*;
#(
   parameter int N_LVL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NEXT-1:0]  ext_pin,
   input  logic [NPER-1:0]  per_evt,
   input  logic [N_LVL-1:0] lvl_mode,
   input  logic             aux_pend,
   input  logic [NSRC-1:0]  clr_vec,
   input  logic [NSRC-1:0]  clr_sw,
   output logic [NSRC-1:0]  flags
);
   generate
      if (N_LVL < 1 || N_LVL > NEXT) begin : g_lvl_chk
         $error("irqc_flags: N_LVL out of range");
      end
   endgenerate

   logic [NEXT-1:0] pin_q;
   logic [NSRC-1:0] flag_q, set_v, live_m, live_v, clr_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= ext_pin;
   end

   always_comb begin
      set_v  = '0;
      live_m = '0;
      live_v = '0;
      for (int k = 0; k < NEXT; k++) set_v[EXT_SRC[k]] = ext_pin[k] & ~pin_q[k];
      for (int k = 0; k < NPER; k++) set_v[PER_SRC[k]] = per_evt[k];
      live_m[AUX_SRC] = 1'b1;
      live_v[AUX_SRC] = aux_pend;
      for (int k = 0; k < N_LVL; k++) begin
         live_m[EXT_SRC[k]] = lvl_mode[k];
         live_v[EXT_SRC[k]] = ext_pin[k];
      end
      clr_v = clr_sw | (clr_vec & HW_CLR) | live_m;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_v) | (set_v & ~live_m);
   end

   assign flags = (flag_q & ~live_m) | (live_v & live_m);
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
module irqc_arbiter
   import irqc_pkg::*;
(
   input  logic [NSRC-1:0]  pend,
   input  logic [NSRC-1:0]  prio_hi,
   output logic             found,
   output logic [IDX_W-1:0] sel_idx,
   output tier_e            sel_tier
);
   logic [NSRC-1:0] hi_v, lo_v;

   assign hi_v  = pend & prio_hi & ~AUX_BIT;
   assign lo_v  = pend & ~prio_hi & ~AUX_BIT;
   assign found = |pend;

   always_comb begin
      if (pend[AUX_SRC]) begin
         sel_idx  = IDX_W'(AUX_SRC);
         sel_tier = TIER_AUX;
      end else if (|hi_v) begin
         sel_idx  = first_set(hi_v);
         sel_tier = TIER_HI;
      end else begin
         sel_idx  = first_set(lo_v);
         sel_tier = TIER_LO;
      end
   end
endmodule

// File: rtl/irqc_lvl_stack.sv
`timescale 1ns/1ps
module irqc_lvl_stack
   import irqc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  tier_e            push_tier,
   input  logic             pop,
   output logic [NTIER-1:0] act,
   output logic [LVL_W-1:0] cur_lvl
);
   logic [NTIER-1:0] act_q, top_m;

   always_comb begin
      top_m   = '0;
      cur_lvl = '0;
      for (int i = 0; i < NTIER; i++) begin
         if (act_q[i]) begin
            top_m   = NTIER'(1) << i;
            cur_lvl = LVL_W'(i + 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q <= '0;
      else if (pop)  act_q <= act_q & ~top_m;
      else if (push) act_q <= act_q | (NTIER'(1) << push_tier);
   end

   assign act = act_q;
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
   import irqc_pkg::*;
#(
   parameter int         DW       = 16,
   parameter int         AUX_W    = 8,
   parameter int         N_LVL    = 2,
   parameter logic [7:0] VEC_BASE = 8'h03,
   parameter int         VEC_STEP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NEXT-1:0]  ext_pin,
   input  logic [NPER-1:0]  per_evt,
   input  logic [AUX_W-1:0] aux_raw,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic             vec_ack,
   input  logic             reti,
   output logic             vec_req,
   output logic [7:0]       vec_addr
);
   localparam int GLB_BIT   = DW - 1;
   localparam int RDSEL_BIT = AUX_W;

   generate
      if (DW < NSRC + 3) begin : g_dw_chk
         $error("irqc_top: DW too narrow for the register fields");
      end
      if (RDSEL_BIT >= GLB_BIT) begin : g_aux_chk
         $error("irqc_top: AUX_W leaves no room for the read-select bit");
      end
      if (int'(VEC_BASE) + VEC_STEP * (NSRC - 1) > 255) begin : g_vec_chk
         $error("irqc_top: vector table exceeds 8 bits");
      end
   endgenerate

   logic [NSRC-1:0]  en_q, prio_q, flags, pend, clr_vec, clr_sw;
   logic             glb_q, rdsel_q, aux_pend, found, acc;
   logic [AUX_W-1:0] msk_q;
   logic [N_LVL-1:0] mode_q;
   logic [IDX_W-1:0] sel_idx;
   tier_e            sel_tier;
   logic [NTIER-1:0] act;
   logic [LVL_W-1:0] cur_lvl;
   reg_sel_e         rsel;
   logic             unused_wdata;

   assign rsel         = reg_sel_e'(reg_addr);
   assign unused_wdata = &{1'b0, reg_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         glb_q   <= 1'b0;
         prio_q  <= '0;
         msk_q   <= '0;
         rdsel_q <= 1'b0;
         mode_q  <= '0;
      end else if (reg_we) begin
         case (rsel)
            RA_ENA: begin
               en_q  <= reg_wdata[NSRC-1:0];
               glb_q <= reg_wdata[GLB_BIT];
            end
            RA_PRIO:   prio_q  <= reg_wdata[NSRC-1:0] & ~AUX_BIT;
            RA_AUXMSK: msk_q   <= reg_wdata[AUX_W-1:0];
            RA_AUXSTS: rdsel_q <= reg_wdata[RDSEL_BIT];
            RA_MODE:   mode_q  <= reg_wdata[N_LVL-1:0];
            default: ;
         endcase
      end
   end

   assign clr_sw   = (reg_we && rsel == RA_FLAG) ? (reg_wdata[NSRC-1:0] & ~AUX_BIT) : '0;
   assign aux_pend = |(aux_raw & msk_q);

   irqc_flags #(.N_LVL(N_LVL)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_pin  (ext_pin),
      .per_evt  (per_evt),
      .lvl_mode (mode_q),
      .aux_pend (aux_pend),
      .clr_vec  (clr_vec),
      .clr_sw   (clr_sw),
      .flags    (flags)
   );

   assign pend = flags & en_q & {NSRC{glb_q}};

   irqc_arbiter u_arb (
      .pend     (pend),
      .prio_hi  (prio_q),
      .found    (found),
      .sel_idx  (sel_idx),
      .sel_tier (sel_tier)
   );

   assign vec_req  = found && ((3'(sel_tier) + 3'd1) > 3'(cur_lvl));
   assign vec_addr = 8'(int'(VEC_BASE) + VEC_STEP * int'(sel_idx));
   assign acc      = vec_ack & vec_req & ~reti;
   assign clr_vec  = acc ? (NSRC'(1) << sel_idx) : '0;

   irqc_lvl_stack u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (acc),
      .push_tier (sel_tier),
      .pop       (reti),
      .act       (act),
      .cur_lvl   (cur_lvl)
   );

   always_comb begin
      reg_rdata = '0;
      case (rsel)
         RA_ENA: begin
            reg_rdata[NSRC-1:0] = en_q;
            reg_rdata[GLB_BIT]  = glb_q;
         end
         RA_PRIO:   reg_rdata[NSRC-1:0]  = prio_q;
         RA_AUXMSK: reg_rdata[AUX_W-1:0] = rdsel_q ? msk_q : aux_raw;
         RA_AUXSTS: begin
            reg_rdata[AUX_W-1:0] = rdsel_q ? aux_raw : msk_q;
            reg_rdata[RDSEL_BIT] = rdsel_q;
         end
         RA_MODE:   reg_rdata[N_LVL-1:0] = mode_q;
         RA_FLAG:   reg_rdata[NSRC-1:0]  = flags;
         default: ;
      endcase
   end
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk #(
   parameter logic [7:0] AUX_VEC = 8'h33
) (
   input logic       clk,
   input logic       rst_n,
   input logic       vec_req,
   input logic [7:0] vec_addr,
   input logic       vec_ack,
   input logic       reti,
   input logic       glb_en,
   input logic       aux_en,
   input logic [2:0] act,
   input logic [3:0] sel_idx,
   input logic       tmr0_evt,
   input logic       tmr0_flag
);
   // R2
   vec_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> vec_addr[2:0] == 3'b011);

   // R6
   glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !vec_req);

   // R5
   aux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && vec_addr == AUX_VEC) |-> aux_en);

   // R7
   tmr0_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && vec_req && !reti && sel_idx == 4'd1 && !tmr0_evt) |=> !tmr0_flag);

   // R10
   push_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && vec_req && !reti) |=> act != 3'b000);

   // R10
   pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && act != 3'b000) |=> ($countones(act) + 1 == $countones($past(act))));
endmodule

bind irqc_top irqc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vec_req   (vec_req),
   .vec_addr  (vec_addr),
   .vec_ack   (vec_ack),
   .reti      (reti),
   .glb_en    (glb_q),
   .aux_en    (en_q[6]),
   .act       (act),
   .sel_idx   (sel_idx),
   .tmr0_evt  (per_evt[0]),
   .tmr0_flag (flags[1])
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  ext_pin = '0;
   logic [5:0]  per_evt = '0;
   logic [7:0]  aux_raw = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        vec_ack = 1'b0;
   logic        reti = 1'b0;
   logic        vec_req;
   logic [7:0]  vec_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irqc_top u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .per_evt(per_evt),
      .aux_raw(aux_raw), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_ack(vec_ack),
      .reti(reti), .vec_req(vec_req), .vec_addr(vec_addr)
   );

   localparam logic [2:0] A_ENA = 3'd0, A_PRIO = 3'd1, A_MSK = 3'd2,
                          A_STS = 3'd3, A_MODE = 3'd4, A_FLAG = 3'd5;

   typedef struct packed {
      logic [15:0] ena;
      logic [15:0] prio;
      logic [7:0]  msk;
      logic [7:0]  raw;
      logic [5:0]  evt;
      logic        req;
      logic [7:0]  addr;
   } tv_t;

   localparam tv_t TBL [9] = '{
      '{16'h9FFF, 16'h0000, 8'h00, 8'h00, 6'h01, 1'b1, 8'h0B}, // R2 single tmr0
      '{16'h9FFF, 16'h1000, 8'h00, 8'h00, 6'h21, 1'b1, 8'h63}, // R4 wdog high over tmr0 low
      '{16'h9FFF, 16'h0000, 8'h00, 8'h00, 6'h12, 1'b1, 8'h1B}, // R3 tmr1 before ser1
      '{16'h9FFF, 16'h0002, 8'h10, 8'h10, 6'h01, 1'b1, 8'h33}, // R4 R5 aux over high tmr0
      '{16'h9FFF, 16'h0000, 8'h01, 8'h10, 6'h08, 1'b1, 8'h2B}, // R5 unmasked aux ignored
      '{16'h1FFF, 16'h0000, 8'h00, 8'h00, 6'h01, 1'b0, 8'h00}, // R6 global enable off
      '{16'h9FFD, 16'h0000, 8'h00, 8'h00, 6'h05, 1'b1, 8'h23}, // R6 tmr0 enable off
      '{16'h9FBF, 16'h0000, 8'hFF, 8'hFF, 6'h10, 1'b1, 8'h3B}, // R5 aux enable off
      '{16'h9FFF, 16'h0080, 8'h00, 8'h00, 6'h1C, 1'b1, 8'h3B}  // R3 R4 ser1 high
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [5:0] e);
      per_evt = e;
      @(negedge clk);
      per_evt = '0;
   endtask

   task automatic ack();
      vec_ack = 1'b1;
      @(negedge clk);
      vec_ack = 1'b0;
   endtask

   task automatic ret();
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 vec_req", vec_req, 0);
      rd(A_ENA, d);  check("R1 enable reg", d, 0);
      rd(A_MODE, d); check("R1 mode reg", d, 0);
      rd(A_FLAG, d); check("R1 flag reg", d, 0);
      @(negedge clk);

      // vector table walk
      for (int i = 0; i < 9; i++) begin
         aux_raw = TBL[i].raw;
         wr(A_FLAG, 16'hFFFF);
         wr(A_MSK, {8'h00, TBL[i].msk});
         wr(A_PRIO, TBL[i].prio);
         wr(A_ENA, TBL[i].ena);
         pulse(TBL[i].evt);
         check($sformatf("R3/R4/R5/R6 row %0d req", i), vec_req, TBL[i].req);
         if (TBL[i].req) check($sformatf("R2/R3/R4 row %0d addr", i), vec_addr, TBL[i].addr);
      end

      // R9 read-select swap
      aux_raw = 8'hA5;
      wr(A_MSK, 16'h003C);
      rd(A_MSK, d); check("R9 sel0 mask addr gives raw", d, 16'h00A5);
      rd(A_STS, d); check("R9 sel0 status addr gives mask", d, 16'h003C);
      @(negedge clk);
      wr(A_STS, 16'h0100);
      rd(A_MSK, d); check("R9 sel1 mask addr gives mask", d, 16'h003C);
      rd(A_STS, d); check("R9 sel1 status addr gives raw", d, 16'h01A5);
      @(negedge clk);
      aux_raw = 8'h00;
      wr(A_STS, 16'h0000);
      wr(A_MSK, 16'h0000);

      // R11 readback masks
      wr(A_ENA, 16'hFFFF);
      rd(A_ENA, d); check("R11 enable readback", d, 16'h9FFF);
      @(negedge clk);
      wr(A_PRIO, 16'hFFFF);
      rd(A_PRIO, d); check("R11 prio readback bit6 zero", d, 16'h1FBF);
      @(negedge clk);

      // R7 R8 external 0 edge then level
      wr(A_FLAG, 16'hFFFF);
      wr(A_ENA, 16'h8001);
      wr(A_PRIO, 16'h0000);
      ext_pin[0] = 1'b1;
      @(negedge clk);
      check("R7 ext0 edge req", vec_req, 1);
      check("R2 ext0 addr", vec_addr, 8'h03);
      ack();
      check("R7 ext0 cleared on vector", vec_req, 0);
      rd(A_FLAG, d); check("R7 ext0 flag clear", d, 16'h0000);
      @(negedge clk);
      ret();
      wr(A_MODE, 16'h0001);
      check("R8 level follows pin high", vec_req, 1);
      ack();
      check("R10 same tier blocked", vec_req, 0);
      ret();
      check("R8 level flag not cleared by vector", vec_req, 1);
      ext_pin[0] = 1'b0;
      @(negedge clk);
      check("R8 level follows pin low", vec_req, 0);
      wr(A_MODE, 16'h0000);

      // R10 preemption and stack
      wr(A_ENA, 16'h8012);
      pulse(6'h01);
      check("R10 tmr0 req", vec_req, 1);
      check("R2 tmr0 addr", vec_addr, 8'h0B);
      ack();
      check("R10 tier0 in service", vec_req, 0);
      rd(A_FLAG, d); check("R7 tmr0 auto clear", d, 16'h0000);
      @(negedge clk);
      pulse(6'h04);
      check("R10 low ser0 cannot preempt low", vec_req, 0);
      wr(A_PRIO, 16'h0010);
      check("R10 high ser0 preempts", vec_req, 1);
      check("R2 ser0 addr", vec_addr, 8'h23);
      ack();
      check("R10 tier1 in service", vec_req, 0);
      ret();
      check("R7 R10 ser0 still pending after pop", vec_req, 1);
      wr(A_FLAG, 16'h0010);
      check("R7 ser0 software clear", vec_req, 0);
      rd(A_FLAG, d); check("R7 flag reg after clear", d, 16'h0000);
      @(negedge clk);
      ret();
      pulse(6'h01);
      check("R10 stack empty after pops", vec_req, 1);
      check("R2 tmr0 addr again", vec_addr, 8'h0B);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule